// File: doc/BRIEF.md
# Power Island Toggle Sequencer

This block switches one indexed power island on or off through a toggle-type power controller interface. A request names an island and the state wanted for it. The block first looks at that island's bit in the incoming status vector. If the bit already shows the wanted state, the block finishes at once. If it does not, the block sends a toggle command and then samples the status bit at a fixed interval until the bit reaches the wanted state. When the controller appears to ignore the command, the block sends the command again. After a fixed number of commands it gives up and reports a busy error.

Islands that hold processor cores use a shorter path. The block sends one toggle command, reports success in the same cycle and does not poll. A second, independent port releases the isolation clamp of an island. It drives out a one-hot mask for the island. Two islands have their mask bits exchanged.

Top module: `pgate_toggle_seq`

## Requirements
- R1: After reset, `tog_valid`, `done`, `busy` and `clamp_valid` are low and stay low until a request arrives.
- R2: An accepted request whose island status bit already equals `req_on` raises `done` with result OK (code 0) in the cycle after acceptance and issues no toggle.
- R3: Every toggle command is the island id in bits 7:0 of `tog_word`, with bit 8 set. Those are the only bits that can be set.
- R4: After the first toggle the status bit is sampled every TICK_CYC cycles, up to SAMPLE_LIMIT (10) samples. A matching sample makes `done` go high with result OK in the cycle after that sample's edge.
- R5: If all SAMPLE_LIMIT samples fail, the toggle is issued again. The sample budget is not reloaded, so each later toggle is followed by exactly one sample.
- R6: At most RETRY_LIMIT (100) toggles are issued per request. If the sample that follows the last toggle still does not match, `done` goes high with result BUSY (code 1). A match on that final sample still gives OK.
- R7: For an island marked in CPU_MASK (default ids 0, 9, 10, 11, 12) that needs a change, exactly one toggle is issued and `done` goes high with OK in the same cycle. No polling follows.
- R8: A request with id at or above NUM_PART (14) raises `done` with result BADID (code 2) in the next cycle and issues no toggle.
- R9: A clamp release for a valid id gives `clamp_valid` one cycle later, with a one-hot `clamp_mask` on bit id. Ids 3 and 4 use each other's bit. An invalid id gives no `clamp_valid`, and `clamp_mask` is zero whenever `clamp_valid` is low.
- R10: `busy` is high while polling. Requests that arrive while `busy` is high are ignored: they cause no toggle and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; accepted when `busy` is low |
| req_id | input | ID_W | Island index of the request |
| req_on | input | 1 | Wanted state: 1 on, 0 off |
| pwr_status | input | NUM_PART | Current power state of every island |
| busy | output | 1 | Polling a toggle in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 BUSY, 2 BADID; valid with `done` |
| tog_valid | output | 1 | One-cycle toggle command strobe |
| tog_word | output | START_BIT+1 | Toggle command: start flag and island id |
| clamp_req | input | 1 | Clamp release strobe |
| clamp_id | input | ID_W | Island whose clamp is released |
| clamp_valid | output | 1 | Clamp mask strobe |
| clamp_mask | output | NUM_PART | One-hot clamp release mask |

## Verification
The hardest path to reach is a late retry, where the controller reacts only to the Nth toggle. In that case the first window uses all ten samples and every later toggle gets only one. The bench models the power switch behind the status vector. It flips the island's bit only when it sees a chosen toggle number, for example the third, the second or the hundredth, or never. This lets each request stop at a known point in the retry sequence, and the bench compares the exact completion cycle and the toggle count with the values worked out from the sampling rule.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_BUSY  = 2'd1,
        RES_BADID = 2'd2
    } pg_result_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_POLL = 1'b1
    } pg_state_e;

    // Bit used for the isolation mask of a given island id
    function automatic int unsigned clamp_remap(input int unsigned id,
                                                input int unsigned swap_a,
                                                input int unsigned swap_b);
        if (id == swap_a) return swap_b;
        if (id == swap_b) return swap_a;
        return id;
    endfunction

endpackage

// File: rtl/pgs_sample_timer.sv
module pgs_sample_timer #(
    parameter int TICK_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic rearm,
    output logic strobe
);
    localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    logic [CW-1:0] cnt;

    assign strobe = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= strobe ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/pgs_poll_engine.sv
module pgs_poll_engine
    import pgs_pkg::*;
#(
    parameter int                NUM_PART     = 14,
    parameter int                ID_W         = 5,
    parameter int                START_BIT    = 8,
    parameter int                SAMPLE_LIMIT = 10,
    parameter int                RETRY_LIMIT  = 100,
    parameter logic [NUM_PART-1:0] CPU_MASK   = '0,
    parameter int                TOG_W        = START_BIT + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ID_W-1:0]     req_id,
    input  logic                req_on,
    input  logic [NUM_PART-1:0] pwr_status,
    input  logic                strobe,
    output logic                rearm,
    output logic                busy,
    output logic                done,
    output pg_result_e          result,
    output logic                tog_valid,
    output logic [TOG_W-1:0]    tog_word
);
    localparam int SC_W = $clog2(SAMPLE_LIMIT + 1);
    localparam int TC_W = $clog2(RETRY_LIMIT + 1);

    pg_state_e       state;
    logic [ID_W-1:0] id_q;
    logic            want_q;
    logic [SC_W-1:0] samples_left;
    logic [TC_W-1:0] tog_count;

    logic cur_bit, cpu_hit, poll_bit, id_ok;
    logic start_cmd, window_out, retry_cmd;
    logic [ID_W-1:0] cmd_id;

    always_comb begin
        cur_bit  = 1'b0;
        cpu_hit  = 1'b0;
        poll_bit = 1'b0;
        for (int i = 0; i < NUM_PART; i++) begin
            if (req_id == ID_W'(i)) begin
                cur_bit = pwr_status[i];
                cpu_hit = CPU_MASK[i];
            end
            if (id_q == ID_W'(i)) poll_bit = pwr_status[i];
        end
    end

    assign id_ok      = ({1'b0, req_id} < (ID_W+1)'(NUM_PART));
    assign start_cmd  = (state == ST_IDLE) && req_valid && id_ok && (cur_bit != req_on);
    assign window_out = (state == ST_POLL) && strobe && (poll_bit != want_q)
                        && (samples_left <= SC_W'(1));
    assign retry_cmd  = window_out && (tog_count != TC_W'(RETRY_LIMIT));
    assign rearm      = start_cmd || retry_cmd;
    assign cmd_id     = (state == ST_IDLE) ? req_id : id_q;
    assign busy       = (state == ST_POLL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            id_q         <= '0;
            want_q       <= 1'b0;
            samples_left <= '0;
            tog_count    <= '0;
            done         <= 1'b0;
            result       <= RES_OK;
            tog_valid    <= 1'b0;
            tog_word     <= '0;
        end else begin
            done      <= 1'b0;
            tog_valid <= rearm;
            if (rearm) begin
                tog_word <= TOG_W'(cmd_id) | (TOG_W'(1) << START_BIT);
            end
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        id_q   <= req_id;
                        want_q <= req_on;
                        if (!id_ok) begin
                            done   <= 1'b1;
                            result <= RES_BADID;
                        end else if (cur_bit == req_on || cpu_hit) begin
                            done   <= 1'b1;
                            result <= RES_OK;
                        end else begin
                            state        <= ST_POLL;
                            samples_left <= SC_W'(SAMPLE_LIMIT);
                            tog_count    <= TC_W'(1);
                        end
                    end
                end
                ST_POLL: begin
                    if (strobe) begin
                        if (poll_bit == want_q) begin
                            done   <= 1'b1;
                            result <= RES_OK;
                            state  <= ST_IDLE;
                        end else if (samples_left > SC_W'(1)) begin
                            samples_left <= samples_left - SC_W'(1);
                        end else begin
                            samples_left <= '0;
                            if (retry_cmd) begin
                                tog_count <= tog_count + TC_W'(1);
                            end else begin
                                done   <= 1'b1;
                                result <= RES_BUSY;
                                state  <= ST_IDLE;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgs_clamp_map.sv
module pgs_clamp_map
    import pgs_pkg::*;
#(
    parameter int NUM_PART = 14,
    parameter int ID_W     = 5,
    parameter int SWAP_A   = 3,
    parameter int SWAP_B   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clamp_req,
    input  logic [ID_W-1:0]     clamp_id,
    output logic                clamp_valid,
    output logic [NUM_PART-1:0] clamp_mask
);
    logic                id_ok;
    int unsigned         tgt;
    logic [NUM_PART-1:0] mask_n;

    assign id_ok = ({1'b0, clamp_id} < (ID_W+1)'(NUM_PART));

    always_comb begin
        tgt = clamp_remap(int'(clamp_id), SWAP_A, SWAP_B);
        for (int i = 0; i < NUM_PART; i++) begin
            mask_n[i] = (tgt == i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_valid <= 1'b0;
            clamp_mask  <= '0;
        end else begin
            clamp_valid <= clamp_req && id_ok;
            clamp_mask  <= (clamp_req && id_ok) ? mask_n : '0;
        end
    end
endmodule

// File: rtl/pgate_toggle_seq.sv
module pgate_toggle_seq
    import pgs_pkg::*;
#(
    parameter int                  NUM_PART     = 14,
    parameter int                  ID_W         = 5,
    parameter int                  START_BIT    = 8,
    parameter int                  TICK_CYC     = 250,
    parameter int                  SAMPLE_LIMIT = 10,
    parameter int                  RETRY_LIMIT  = 100,
    parameter logic [NUM_PART-1:0] CPU_MASK     = 14'b01_1110_0000_0001,
    parameter int                  SWAP_A       = 3,
    parameter int                  SWAP_B       = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [ID_W-1:0]        req_id,
    input  logic                   req_on,
    input  logic [NUM_PART-1:0]    pwr_status,
    output logic                   busy,
    output logic                   done,
    output logic [1:0]             result,
    output logic                   tog_valid,
    output logic [START_BIT:0]     tog_word,
    input  logic                   clamp_req,
    input  logic [ID_W-1:0]        clamp_id,
    output logic                   clamp_valid,
    output logic [NUM_PART-1:0]    clamp_mask
);
    localparam int TOG_W = START_BIT + 1;

    logic       strobe;
    logic       rearm;
    pg_result_e res_e;

    pgs_sample_timer #(.TICK_CYC(TICK_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .rearm  (rearm),
        .strobe (strobe)
    );

    pgs_poll_engine #(
        .NUM_PART     (NUM_PART),
        .ID_W         (ID_W),
        .START_BIT    (START_BIT),
        .SAMPLE_LIMIT (SAMPLE_LIMIT),
        .RETRY_LIMIT  (RETRY_LIMIT),
        .CPU_MASK     (CPU_MASK),
        .TOG_W        (TOG_W)
    ) u_engine (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_id     (req_id),
        .req_on     (req_on),
        .pwr_status (pwr_status),
        .strobe     (strobe),
        .rearm      (rearm),
        .busy       (busy),
        .done       (done),
        .result     (res_e),
        .tog_valid  (tog_valid),
        .tog_word   (tog_word)
    );

    assign result = res_e;

    pgs_clamp_map #(
        .NUM_PART (NUM_PART),
        .ID_W     (ID_W),
        .SWAP_A   (SWAP_A),
        .SWAP_B   (SWAP_B)
    ) u_clamp (
        .clk         (clk),
        .rst         (rst),
        .clamp_req   (clamp_req),
        .clamp_id    (clamp_id),
        .clamp_valid (clamp_valid),
        .clamp_mask  (clamp_mask)
    );
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
    parameter int NUM_PART  = 14,
    parameter int START_BIT = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                busy,
    input logic                done,
    input logic [1:0]          result,
    input logic                tog_valid,
    input logic [START_BIT:0]  tog_word,
    input logic                clamp_valid,
    input logic [NUM_PART-1:0] clamp_mask
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!tog_valid && !done && !busy && !clamp_valid)); // R1

    AST_TOG_START_SET: assert property (@(posedge clk) disable iff (rst)
        tog_valid |-> tog_word[START_BIT]); // R3

    AST_TOG_ID_RANGE: assert property (@(posedge clk) disable iff (rst)
        tog_valid |-> (int'(tog_word[START_BIT-1:0]) < NUM_PART)); // R3

    AST_BUSY_FROM_POLL: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd1) |-> $past(busy)); // R6

    AST_BADID_NO_TOG: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd2) |-> !tog_valid); // R8

    AST_CLAMP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        clamp_valid |-> ($countones(clamp_mask) == 1)); // R9

    AST_CLAMP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !clamp_valid |-> (clamp_mask == '0)); // R9

    AST_DONE_LEAVES_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10
endmodule

bind pgate_toggle_seq pgs_checker #(
    .NUM_PART  (NUM_PART),
    .START_BIT (START_BIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .tog_valid   (tog_valid),
    .tog_word    (tog_word),
    .clamp_valid (clamp_valid),
    .clamp_mask  (clamp_mask)
);

// File: tb/pgate_toggle_seq_tb.sv
`timescale 1ns/1ps
module pgate_toggle_seq_tb;
    localparam int NP  = 14;
    localparam int IW  = 5;
    localparam int T   = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_id = '0;
    logic          req_on = 1'b0;
    logic [NP-1:0] stat = '0;
    logic          busy, done, tog_valid, clamp_valid;
    logic [1:0]    result;
    logic [8:0]    tog_word;
    logic          clamp_req = 1'b0;
    logic [IW-1:0] clamp_id = '0;
    logic [NP-1:0] clamp_mask;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pgate_toggle_seq #(.TICK_CYC(T)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id),
        .req_on(req_on), .pwr_status(stat), .busy(busy), .done(done),
        .result(result), .tog_valid(tog_valid), .tog_word(tog_word),
        .clamp_req(clamp_req), .clamp_id(clamp_id),
        .clamp_valid(clamp_valid), .clamp_mask(clamp_mask)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One request; the bench switch model flips the island bit when it sees toggle flip_at
    task automatic run_req(input int id, input bit on, input bit init, input int flip_at,
                           input int exp_n, input int exp_tog, input int exp_res,
                           input bit intrude, input string tag);
        int n = 0;
        int ntog = 0;
        int bad_words = 0;
        int res = -1;
        int late_tog = 0;
        int late_done = 0;
        bit got = 0;
        @(negedge clk);
        if (id < NP) stat[id] = init;
        req_valid = 1'b1;
        req_id    = IW'(id);
        req_on    = on;
        while (!got && n < exp_n + 20) begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 1'b0;
            if (n == 1 && exp_n > 1) chk(busy == 1'b1, "R10", "busy while polling", busy, 1);
            if (intrude && n == 3) begin
                req_valid = 1'b1; req_id = IW'(2); req_on = 1'b1;
            end
            if (intrude && n == 4) req_valid = 1'b0;
            if (tog_valid) begin
                ntog++;
                if (tog_word != (9'h100 | 9'(id))) bad_words++;
                if (ntog == flip_at) stat[id] = ~stat[id];
            end
            if (done) begin
                got = 1;
                res = int'(result);
            end
        end
        for (int k = 0; k < 3 * T; k++) begin
            @(negedge clk);
            if (tog_valid) late_tog++;
            if (done) late_done++;
        end
        chk(n == exp_n, tag, "completion cycle", n, exp_n);
        chk(ntog == exp_tog, tag, "toggle count", ntog, exp_tog);
        chk(res == exp_res, tag, "result code", res, exp_res);
        chk(bad_words == 0, "R3", "malformed toggle words", bad_words, 0);
        chk(late_tog == 0 && late_done == 0, tag, "activity after completion",
            late_tog + late_done, 0);
    endtask

    task automatic test_reset();
        int act = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (tog_valid || done || busy || clamp_valid) act++;
        end
        chk(act == 0, "R1", "outputs idle after reset", act, 0);
    endtask

    task automatic test_clamp(input int id, input int exp_bit, input string tag);
        logic [NP-1:0] expm;
        @(negedge clk);
        clamp_req = 1'b1;
        clamp_id  = IW'(id);
        @(negedge clk);
        clamp_req = 1'b0;
        expm = (exp_bit >= 0) ? (NP'(1) << exp_bit) : '0;
        chk(clamp_valid == (exp_bit >= 0), tag, "clamp_valid", clamp_valid, exp_bit >= 0);
        chk(clamp_mask == expm, tag, "clamp_mask", int'(clamp_mask), int'(expm));
        @(negedge clk);
        chk(clamp_valid == 1'b0 && clamp_mask == '0, tag, "clamp pulse ends",
            int'(clamp_mask), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();                                                     // R1
        stat = '0;
        run_req(5, 1'b1, 1'b1, 0, 1, 0, 0, 1'b0, "R2");                   // already on
        run_req(6, 1'b1, 1'b0, 1, T + 1, 1, 0, 1'b0, "R4");               // first sample hits
        run_req(7, 1'b1, 1'b0, 3, 12 * T + 1, 3, 0, 1'b0, "R5");          // third toggle works
        run_req(13, 1'b0, 1'b1, 2, 11 * T + 1, 2, 0, 1'b0, "R5");         // power off, second toggle
        run_req(8, 1'b1, 1'b0, 0, 109 * T + 1, 100, 1, 1'b1, "R6");       // never responds, intruder
        run_req(8, 1'b1, 1'b0, 100, 109 * T + 1, 100, 0, 1'b0, "R6");     // responds on last toggle
        chk(stat[2] == 1'b0, "R10", "intruding island untouched", stat[2], 0);
        run_req(0, 1'b1, 1'b0, 0, 1, 1, 0, 1'b0, "R7");                   // cpu fast path
        run_req(11, 1'b1, 1'b0, 0, 1, 1, 0, 1'b0, "R7");
        run_req(20, 1'b1, 1'b0, 0, 1, 0, 2, 1'b0, "R8");                  // out of range
        run_req(14, 1'b0, 1'b0, 0, 1, 0, 2, 1'b0, "R8");
        test_clamp(3, 4, "R9");
        test_clamp(4, 3, "R9");
        test_clamp(5, 5, "R9");
        test_clamp(20, -1, "R9");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule